// File: doc/BRIEF.md
# Strobed Serial Command Port

This block is the host-facing serial port of a display controller. A host drives three wires: a frame strobe, a shift clock and a data line. The port also has one open-drain return line. While the strobe is low the port gathers bits into bytes, least significant bit first, and takes each bit when the shift clock rises. The first byte of each strobe-low frame is presented as a command. Every later byte in that frame is presented as a data byte, together with its position in the frame.

When a command selects reading, the port stops presenting data bytes. It shifts a byte from its parallel input out on the return line instead. Output bits change after the shift clock falls. A logic 0 is sent by pulling the line low, and a logic 1 by releasing it. Outside a read, the line is always released.

All three serial inputs are oversampled by the system clock. Both edges of the strobe abort whatever is in progress. The command and data outputs are single-cycle pulses with no back-pressure: the downstream logic must take each pulse in the cycle it appears, because the serial host cannot be stalled.

Top module: `ser_cmd_if`

## Requirements
- R1: Serial bits are taken on rising shift-clock edges and assembled least significant bit first: the first bit of a byte lands in bit 0 and the eighth bit lands in bit 7.
- R2: The first complete byte after the strobe falls raises `cmd_valid_o` for exactly one cycle, with that byte on `cmd_byte_o`.
- R3: Each further complete byte in the same frame raises `data_valid_o` for one cycle, with the byte on `data_byte_o`. `data_idx_o` is 0 for the first data byte of the frame and increases by 1 for each later one.
- R4: Shift-clock edges that occur while the strobe is high produce no command or data pulse and leave no bits behind for the next frame.
- R5: A rising or falling strobe edge discards a partly received byte. After the strobe has fallen again, the next complete byte is a command.
- R6: A command whose bits [7:6] equal 2'b01 enters read mode for the rest of the frame. In read mode no data pulses are produced. At the first falling shift-clock edge of each byte, `tx_byte_i` is sampled, and its bits appear on the return line least significant bit first, each one changing after a falling shift-clock edge.
- R7: `sdo_low_o` is high only while a 0 bit is being sent in read mode. Outside read mode, and once the strobe has returned high, the line is released.
- R8: If a strobe edge and the shift-clock edge that would complete a byte are seen in the same system cycle, the abort wins and no pulse is produced.
- R9: During and directly after reset, both pulse outputs and `sdo_low_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_i | input | 1 | Frame strobe; a frame is active while it is low |
| sclk_i | input | 1 | Shift clock from the host; idles high |
| sdi_i | input | 1 | Serial data from the host |
| tx_byte_i | input | 8 | Byte to send in read mode |
| sdo_low_o | output | 1 | Open-drain control: 1 pulls the return line low, 0 releases it |
| cmd_valid_o | output | 1 | One-cycle pulse marking a command byte |
| cmd_byte_o | output | 8 | Received command byte |
| data_valid_o | output | 1 | One-cycle pulse marking a data byte |
| data_byte_o | output | 8 | Received data byte |
| data_idx_o | output | IDX_W | Position of the data byte within the frame |

## Verification
The case that needs care is a strobe edge and a byte-completing shift-clock edge landing in the same system cycle. Either one alone has a clear outcome: the strobe edge aborts, and the clock edge delivers a byte. The bench provokes the collision by raising the strobe and the shift clock at the same instant on the eighth bit of a data byte. Both signals then pass through synchronisers of equal depth, so their edges are detected in the same cycle. The bench judges the outcome by requiring that no data pulse appears, while the earlier command pulse still counts. A second collision raises the strobe partway through a read byte and confirms that the return line is released afterwards.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
  // command bits [7:6] value that selects a read frame
  localparam logic [1:0] RD_TAG = 2'b01;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1, s2, prev;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]   <= RST_VAL[g];
        s2[g]   <= RST_VAL[g];
        prev[g] <= RST_VAL[g];
      end else begin
        s1[g]   <= d_i[g];
        s2[g]   <= s1[g];
        prev[g] <= s2[g];
      end
    end
    assign rise_o[g] = s2[g] & ~prev[g];
    assign fall_o[g] = ~s2[g] & prev[g];
  end

  assign lvl_o = s2;
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             take_i,
  input  logic             sdi_i,
  output logic             rd_mode_o,
  output logic             cmd_valid_o,
  output byte_t            cmd_byte_o,
  output logic             data_valid_o,
  output byte_t            data_byte_o,
  output logic [IDX_W-1:0] data_idx_o
);
  byte_t             sh;
  logic [BIT_CW-1:0] cnt;
  logic              first;
  logic [IDX_W-1:0]  idx;
  byte_t             nb;

  assign nb = {sdi_i, sh[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh           <= '0;
      cnt          <= '0;
      first        <= 1'b1;
      idx          <= '0;
      rd_mode_o    <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_byte_o   <= '0;
      data_valid_o <= 1'b0;
      data_byte_o  <= '0;
      data_idx_o   <= '0;
    end else begin
      cmd_valid_o  <= 1'b0;
      data_valid_o <= 1'b0;
      if (abort_i) begin
        cnt       <= '0;
        first     <= 1'b1;
        idx       <= '0;
        rd_mode_o <= 1'b0;
      end else if (take_i) begin
        sh <= nb;
        if (cnt == BIT_CW'(BYTE_W - 1)) begin
          cnt <= '0;
          if (first) begin
            first       <= 1'b0;
            cmd_valid_o <= 1'b1;
            cmd_byte_o  <= nb;
            rd_mode_o   <= (nb[BYTE_W-1 -: 2] == RD_TAG);
          end else if (!rd_mode_o) begin
            data_valid_o <= 1'b1;
            data_byte_o  <= nb;
            data_idx_o   <= idx;
            idx          <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  abort_i,
  input  logic  rd_mode_i,
  input  logic  shift_i,
  input  byte_t tx_byte_i,
  output logic  sdo_low_o
);
  logic [BYTE_W-2:0] sh;
  logic [BIT_CW-1:0] cnt;
  logic              bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      bit_q <= 1'b1;
    end else if (abort_i || !rd_mode_i) begin
      cnt   <= '0;
      bit_q <= 1'b1;
    end else if (shift_i) begin
      if (cnt == '0) begin
        bit_q <= tx_byte_i[0];
        sh    <= tx_byte_i[BYTE_W-1:1];
      end else begin
        bit_q <= sh[0];
        sh    <= {1'b0, sh[BYTE_W-2:1]};
      end
      cnt <= cnt + 1'b1;
    end
  end

  assign sdo_low_o = ~bit_q;
endmodule

// File: rtl/ser_cmd_if.sv
module ser_cmd_if
  import ser_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [7:0]       tx_byte_i,
  output logic             sdo_low_o,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_byte_o,
  output logic             data_valid_o,
  output logic [7:0]       data_byte_o,
  output logic [IDX_W-1:0] data_idx_o
);
  localparam int PIN_STB = 2;
  localparam int PIN_CLK = 1;
  localparam int PIN_DAT = 0;

  logic [2:0] lvl, rise, fall;
  logic abort, take, shift, rd_mode;

  ser_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({strb_i, sclk_i, sdi_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign abort = rise[PIN_STB] | fall[PIN_STB];
  assign take  = rise[PIN_CLK] & ~lvl[PIN_STB];
  assign shift = fall[PIN_CLK] & ~lvl[PIN_STB];

  ser_rx #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .take_i(take),
    .sdi_i(lvl[PIN_DAT]), .rd_mode_o(rd_mode),
    .cmd_valid_o(cmd_valid_o), .cmd_byte_o(cmd_byte_o),
    .data_valid_o(data_valid_o), .data_byte_o(data_byte_o),
    .data_idx_o(data_idx_o)
  );

  ser_tx u_tx (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .rd_mode_i(rd_mode),
    .shift_i(shift), .tx_byte_i(tx_byte_i), .sdo_low_o(sdo_low_o)
  );
endmodule

// File: rtl/ser_cmd_if_chk.sv
module ser_cmd_if_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strb_i,
  input logic             sdo_low_o,
  input logic             cmd_valid_o,
  input logic             data_valid_o,
  input logic [IDX_W-1:0] data_idx_o
);
  logic [IDX_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= '0;
    else if (cmd_valid_o)  seen <= '0;
    else if (data_valid_o) seen <= seen + 1'b1;
  end

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R3
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> !data_valid_o);

  // R3
  data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (data_idx_o == seen));

  // R2
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && data_valid_o));

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_i && $past(strb_i) && $past(strb_i, 2) && $past(strb_i, 3)
     && $past(strb_i, 4) && $past(strb_i, 5)) |-> !sdo_low_o);
endmodule

bind ser_cmd_if ser_cmd_if_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .sdo_low_o(sdo_low_o),
  .cmd_valid_o(cmd_valid_o), .data_valid_o(data_valid_o),
  .data_idx_o(data_idx_o)
);

// File: tb/ser_cmd_if_tb.sv
module ser_cmd_if_tb;
  localparam int IDX_W = 4;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strb = 1'b1, sclk = 1'b1, sdi = 1'b1;
  logic [7:0] tx = 8'h00;
  logic sdo_low, cmd_v, data_v;
  logic [7:0] cmd_b, data_b;
  logic [IDX_W-1:0] data_idx;

  int checks = 0, errors = 0;
  int cmd_cnt = 0, data_cnt = 0;
  logic [7:0] last_cmd;
  logic [7:0] got_data [16];
  logic [IDX_W-1:0] got_idx [16];
  bit done = 0;

  always #10 clk = ~clk;

  ser_cmd_if #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strb_i(strb), .sclk_i(sclk), .sdi_i(sdi),
    .tx_byte_i(tx), .sdo_low_o(sdo_low), .cmd_valid_o(cmd_v),
    .cmd_byte_o(cmd_b), .data_valid_o(data_v), .data_byte_o(data_b),
    .data_idx_o(data_idx)
  );

  always @(posedge clk) begin
    if (cmd_v) begin cmd_cnt = cmd_cnt + 1; last_cmd = cmd_b; end
    if (data_v) begin
      if (data_cnt < 16) begin
        got_data[data_cnt] = data_b;
        got_idx[data_cnt] = data_idx;
      end
      data_cnt = data_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    cmd_cnt = 0; data_cnt = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic [7:0] rb);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = b[i];
      wt(H);
      rb[i] = ~sdo_low;
      sclk = 1'b1;
      wt(H);
    end
  endtask

  task automatic open_frame(); strb = 1'b0; wt(H); endtask
  task automatic close_frame(); wt(H); strb = 1'b1; wt(3 * H); endtask

  logic [7:0] rb, exp_d;
  bit is_rd;

  initial begin
    wt(3);
    // R9: reset state
    chk(!cmd_v && !data_v && !sdo_low, "R9", {cmd_v, data_v, sdo_low}, 0);
    rst_n = 1'b1;
    wt(4);
    chk(!cmd_v && !data_v && !sdo_low, "R9", {cmd_v, data_v, sdo_low}, 0);

    // full sweep of command values, one follow-up byte each
    for (int c = 0; c < 256; c++) begin
      clear_mon();
      is_rd = (c[7:6] == 2'b01);
      exp_d = 8'(c) ^ 8'h3C;
      tx = ~8'(c) ^ 8'h96;
      open_frame();
      put_byte(8'(c), rb);
      put_byte(exp_d, rb);
      close_frame();
      // R1 R2
      chk(cmd_cnt == 1 && last_cmd == 8'(c), "R1/R2 cmd", last_cmd, c);
      if (is_rd) begin
        // R6
        chk(data_cnt == 0, "R6 no data in read", data_cnt, 0);
        chk(rb == tx, "R6 read bits", rb, tx);
      end else begin
        // R3
        chk(data_cnt == 1 && got_data[0] == exp_d && got_idx[0] == 0,
            "R3 data", got_data[0], exp_d);
        // R7
        chk(rb == 8'hFF, "R7 released", rb, 8'hFF);
      end
      chk(!sdo_low, "R7 idle", sdo_low, 0);
    end

    // R3: index progression over six data bytes
    clear_mon();
    open_frame();
    put_byte(8'h03, rb);
    for (int k = 0; k < 6; k++) put_byte(8'(8'h11 * k + 8'h05), rb);
    close_frame();
    chk(data_cnt == 6, "R3 count", data_cnt, 6);
    for (int k = 0; k < 6; k++)
      chk(got_idx[k] == IDX_W'(k) && got_data[k] == 8'(8'h11 * k + 8'h05),
          "R3 idx", got_idx[k], k);

    // R6: multi-byte read, tx changed between bytes
    clear_mon();
    open_frame();
    put_byte(8'h42, rb);
    for (int k = 0; k < 3; k++) begin
      tx = 8'(8'hC3 + 8'h29 * k);
      put_byte(8'h00, rb);
      chk(rb == tx, "R6 multi read", rb, tx);
    end
    close_frame();
    chk(data_cnt == 0, "R6 multi no data", data_cnt, 0);

    // R4: clocks while strobe high
    clear_mon();
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b0; sdi = k[0]; wt(H); sclk = 1'b1; wt(H);
    end
    chk(cmd_cnt == 0 && data_cnt == 0, "R4 ignored", cmd_cnt + data_cnt, 0);
    open_frame();
    put_byte(8'h11, rb);
    close_frame();
    chk(cmd_cnt == 1 && last_cmd == 8'h11, "R4 clean frame", last_cmd, 8'h11);

    // R5: abort partway through a command byte
    clear_mon();
    open_frame();
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1; wt(H); sclk = 1'b1; wt(H);
    end
    strb = 1'b1; wt(3 * H);
    chk(cmd_cnt == 0, "R5 no cmd", cmd_cnt, 0);
    open_frame();
    put_byte(8'hA7, rb);
    put_byte(8'h5A, rb);
    close_frame();
    chk(cmd_cnt == 1 && last_cmd == 8'hA7, "R5 cmd after abort", last_cmd, 8'hA7);
    chk(data_cnt == 1 && got_data[0] == 8'h5A, "R5 data after abort", got_data[0], 8'h5A);

    // R5: abort partway through a data byte
    clear_mon();
    open_frame();
    put_byte(8'h2B, rb);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; sdi = 1'b0; wt(H); sclk = 1'b1; wt(H);
    end
    close_frame();
    chk(data_cnt == 0, "R5 data dropped", data_cnt, 0);

    // R8: strobe rise together with the completing clock rise
    clear_mon();
    open_frame();
    put_byte(8'h20, rb);
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b0; sdi = 1'b1; wt(H); sclk = 1'b1; wt(H);
    end
    sclk = 1'b0; wt(H);
    sclk = 1'b1; strb = 1'b1;
    wt(4 * H);
    chk(cmd_cnt == 1, "R8 cmd kept", cmd_cnt, 1);
    chk(data_cnt == 0, "R8 abort wins", data_cnt, 0);

    // R7/R8: abort during a read byte releases the line
    clear_mon();
    tx = 8'h00;
    open_frame();
    put_byte(8'h40, rb);
    sclk = 1'b0; wt(H);
    chk(sdo_low, "R7 drives zero", sdo_low, 1);
    sclk = 1'b1; strb = 1'b1;
    wt(3 * H);
    chk(!sdo_low, "R7 release on abort", sdo_low, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule